// File: doc/BRIEF.md
# Parking Bus Arbiter with Rotating Priority

This block is the central arbiter of a shared parallel bus with five masters. Each master asks for the bus on its own active-low request line. The arbiter answers on a matching active-low grant line and never grants more than one master at a time. It watches the bus's active-low frame and initiator-ready signals to tell when the granted master has actually begun a transaction. It also uses them to tell when the bus is idle.

A parameter selects one of two schemes for choosing the next owner. In the fair scheme the search starts just after the current owner and skips masters that are not asking. In the pure scheme a priority pointer moves on by one position after every grant that answers a request. With no requests pending, the grant rests on a parking master. That master is either the last owner or a fixed master chosen by parameter, so a later request from it costs no arbitration. Arbitration is hidden: the grant may move while the previous owner is still finishing its transfer. A grant that a requesting master does not use within a fixed number of idle bus cycles is taken back and offered to the next master.

Top module: `pci_park_arbiter`

## Requirements
- R1: At most one grant output is low in any cycle, and every grant output comes straight from a register.
- R2: While reset is asserted, all grant outputs are high. After reset the parking master is master 0, so with no requests pending the first grant goes to master 0 (last-owner mode).
- R3: A grant never passes directly from one master to another. Between two different owners there is at least one cycle with every grant high.
- R4: If every request line has been high for two consecutive cycles, some grant is low in the following cycle. In last-owner mode, the master that used the bus last keeps the grant while no one requests.
- R5: With fixed parking enabled, two consecutive cycles with no requests leave the grant on the chosen parking master in the next cycle. A different idle owner gives up its grant, and the grant moves to the parking master.
- R6: A granted master that is not requesting, or that has already started a transaction, loses its grant in the cycle after another master requests. This happens even while frame or irdy is still low.
- R7: A transaction is recognised as started when frame_n is low in a cycle and both frame_n and irdy_n were high in the cycle before, while a grant is held.
- R8: If the granted master keeps requesting but starts no transaction for 16 cycles in which frame_n and irdy_n are both high, its grant is removed. The next master in search order is then granted.
- R9: In fair mode (PURE_ROTATION=0), the search for the next owner begins at the master just after the current owner, wraps from 4 to 0, and picks the first master whose request is low.
- R10: In pure mode (PURE_ROTATION=1), the search begins at a pointer that starts at 0 and advances by one after each grant made to a requester. Parking grants leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| req_n | input | NUM_MST | Active-low request, one bit per master |
| frame_n | input | 1 | Active-low bus frame signal |
| irdy_n | input | 1 | Active-low initiator-ready signal |
| gnt_n | output | NUM_MST | Active-low registered grant, one bit per master |

## Verification
The hardest situation to reach is the unused-grant timeout. The owner has to keep requesting while the bus stays idle, and no other trigger may fire for sixteen cycles. The stimulus reaches it by leaving a second master requesting throughout the window, which also checks that the withdrawn grant lands on that master. Hidden arbitration needs a request from another master to arrive while frame or irdy is still low. The stimulus table contains such a row. It runs the same sequence through a fair, last-owner arbiter and a pure, fixed-parking arbiter at once, so the two rotation schemes visibly pick different owners on the same request pattern.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [0:0] {
    ARB_GAP = 1'b0,
    ARB_OWN = 1'b1
  } arb_state_e;

  // modular add for index arithmetic on small master counts
  function automatic int wrap_add(input int a, input int b, input int n);
    int s;
    s = a + b;
    while (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int NUM_MST = 5,
  parameter int IW      = 3
) (
  input  logic [NUM_MST-1:0] req_vec,
  input  logic [IW-1:0]      base,
  output logic               found,
  output logic [IW-1:0]      pick
);
  import arb_pkg::*;

  // search from base upward with wrap; the lowest offset wins,
  // so walk offsets from the top down and let later hits override
  always_comb begin
    found = 1'b0;
    pick  = base;
    for (int k = NUM_MST - 1; k >= 0; k--) begin
      int s;
      s = wrap_add(int'(base), k, NUM_MST);
      if (req_vec[s]) begin
        found = 1'b1;
        pick  = IW'(s);
      end
    end
  end

endmodule

// File: rtl/arb_bus_mon.sv
module arb_bus_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  output logic bus_idle,
  output logic start_now
);

  logic idle_q;
  logic idle_d;

  assign bus_idle  = frame_n & irdy_n;
  assign start_now = ~frame_n & idle_q;

  always_comb begin
    idle_d = bus_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b1;
    end else begin
      idle_q <= idle_d;
    end
  end

endmodule

// File: rtl/arb_grant_timer.sv
module arb_grant_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cnt_en,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_we;

  assign expired = cnt_en && (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    cnt_we = 1'b0;
    cnt_d  = cnt_q;
    if (clr || expired) begin
      cnt_we = 1'b1;
      cnt_d  = '0;
    end else if (cnt_en) begin
      cnt_we = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pci_park_arbiter.sv
module pci_park_arbiter #(
  parameter int NUM_MST       = 5,
  parameter int GRANT_TIMEOUT = 16,
  parameter int PURE_ROTATION = 0,
  parameter int PARK_FIXED    = 0,
  parameter int PARK_MASTER   = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MST-1:0] req_n,
  input  logic               frame_n,
  input  logic               irdy_n,
  output logic [NUM_MST-1:0] gnt_n
);
  import arb_pkg::*;

  localparam int IW = (NUM_MST > 1) ? $clog2(NUM_MST) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NUM_MST - 1);
  localparam logic [IW-1:0] PARK_IDX = IW'(PARK_MASTER);

  arb_state_e         state_q, state_d;
  logic [IW-1:0]      owner_q, owner_d;
  logic [IW-1:0]      ptr_q, ptr_d;
  logic               started_q, started_d;
  logic [NUM_MST-1:0] gnt_q, gnt_d;

  logic [NUM_MST-1:0] req_act;
  logic [NUM_MST-1:0] owner_oh;
  logic               owner_req;
  logic               any_other;
  logic               any_req;
  logic [IW-1:0]      search_base;
  logic [IW-1:0]      ptr_step;
  logic [IW-1:0]      park_idx;
  logic               park_move;
  logic               found;
  logic [IW-1:0]      pick;
  logic               bus_idle;
  logic               start_now;
  logic               expired;
  logic               tmr_clr;
  logic               tmr_en;
  logic               leave;
  logic [IW-1:0]      new_owner;

  assign req_act   = ~req_n;
  assign owner_oh  = NUM_MST'(1) << owner_q;
  assign owner_req = |(req_act & owner_oh);
  assign any_other = |(req_act & ~owner_oh);
  assign any_req   = |req_act;

  // rotation scheme select
  generate
    if (PURE_ROTATION != 0) begin : g_pure
      assign search_base = ptr_q;
      assign ptr_step    = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
    end else begin : g_fair
      assign search_base = (owner_q == LAST_IDX) ? '0 : owner_q + 1'b1;
      assign ptr_step    = ptr_q;
    end
  endgenerate

  // parking target select
  generate
    if (PARK_FIXED != 0) begin : g_park_fixed
      assign park_idx  = PARK_IDX;
      assign park_move = !any_req && (owner_q != PARK_IDX);
    end else begin : g_park_last
      assign park_idx  = owner_q;
      assign park_move = 1'b0;
    end
  endgenerate

  arb_pick #(
    .NUM_MST (NUM_MST),
    .IW      (IW)
  ) u_pick (
    .req_vec (req_act),
    .base    (search_base),
    .found   (found),
    .pick    (pick)
  );

  arb_bus_mon u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .bus_idle  (bus_idle),
    .start_now (start_now)
  );

  assign tmr_clr = (state_q == ARB_GAP);
  assign tmr_en  = (state_q == ARB_OWN) && owner_req && !started_q &&
                   !start_now && bus_idle;

  arb_grant_timer #(
    .LIMIT (GRANT_TIMEOUT)
  ) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .cnt_en  (tmr_en),
    .expired (expired)
  );

  assign leave = (started_q && any_other) ||
                 (!owner_req && any_other) ||
                 expired ||
                 park_move;

  assign new_owner = found ? pick : park_idx;

  always_comb begin
    state_d   = state_q;
    owner_d   = owner_q;
    ptr_d     = ptr_q;
    started_d = started_q;
    gnt_d     = gnt_q;
    case (state_q)
      ARB_GAP: begin
        state_d   = ARB_OWN;
        started_d = 1'b0;
        owner_d   = new_owner;
        gnt_d     = NUM_MST'(1) << new_owner;
        if (found) begin
          ptr_d = ptr_step;
        end
      end
      ARB_OWN: begin
        started_d = started_q | start_now;
        if (leave) begin
          state_d = ARB_GAP;
          gnt_d   = '0;
        end
      end
      default: begin
        state_d = ARB_GAP;
        gnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ARB_GAP;
      owner_q   <= '0;
      ptr_q     <= '0;
      started_q <= 1'b0;
      gnt_q     <= '0;
    end else begin
      state_q   <= state_d;
      owner_q   <= owner_d;
      ptr_q     <= ptr_d;
      started_q <= started_d;
      gnt_q     <= gnt_d;
    end
  end

  assign gnt_n = ~gnt_q;

endmodule

// File: rtl/pci_park_arbiter_chk.sv
module pci_park_arbiter_chk #(
  parameter int NUM_MST       = 5,
  parameter int GRANT_TIMEOUT = 16,
  parameter int PARK_FIXED    = 0,
  parameter int PARK_MASTER   = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_MST-1:0] req_n,
  input logic               frame_n,
  input logic               irdy_n,
  input logic [NUM_MST-1:0] gnt_n
);
  localparam int CW = $clog2(GRANT_TIMEOUT + 2);
  localparam logic [NUM_MST-1:0] PARK_OH = NUM_MST'(1) << PARK_MASTER;

  logic [CW-1:0] hold_cnt;
  logic          used_q;
  logic          idle_q;
  logic          held;

  assign held = (gnt_n != '1);

  // independent count of idle cycles an unused, still-requested grant sits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      used_q   <= 1'b0;
      idle_q   <= 1'b1;
    end else begin
      idle_q <= frame_n & irdy_n;
      if (!held) begin
        hold_cnt <= '0;
        used_q   <= 1'b0;
      end else begin
        if (!frame_n && idle_q) used_q <= 1'b1;
        if (|(~gnt_n & ~req_n) && !used_q && frame_n && irdy_n &&
            hold_cnt != {CW{1'b1}}) begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~gnt_n) <= 1); // R1

  AST_GAP_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $past(gnt_n) != '1) |-> (gnt_n == $past(gnt_n))); // R3

  AST_PARK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_n == '1 && $past(req_n) == '1) |=> held); // R4

  AST_UNUSED_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_cnt == CW'(GRANT_TIMEOUT)) |-> !held); // R8

  generate
    if (PARK_FIXED != 0) begin : g_fixed_chk
      AST_FIXED_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_n == '1 && $past(req_n) == '1) |=> (gnt_n == ~PARK_OH)); // R5
    end
  endgenerate

endmodule

bind pci_park_arbiter pci_park_arbiter_chk #(
  .NUM_MST       (NUM_MST),
  .GRANT_TIMEOUT (GRANT_TIMEOUT),
  .PARK_FIXED    (PARK_FIXED),
  .PARK_MASTER   (PARK_MASTER)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_n   (req_n),
  .frame_n (frame_n),
  .irdy_n  (irdy_n),
  .gnt_n   (gnt_n)
);

// File: tb/test_pci_park_arbiter.sv
`timescale 1ns/1ps
module test_pci_park_arbiter;

  logic       clk;
  logic       rst_n;
  logic [4:0] req_n;
  logic       frame_n;
  logic       irdy_n;
  logic [4:0] gnt_f_n;
  logic [4:0] gnt_p_n;
  int         checks;
  int         failures;
  bit         done;

  // fair rotation, park on last owner
  pci_park_arbiter i_pci_park_arbiter (
    .clk (clk), .rst_n (rst_n), .req_n (req_n),
    .frame_n (frame_n), .irdy_n (irdy_n), .gnt_n (gnt_f_n)
  );

  // pure rotation, fixed parking on master 3
  pci_park_arbiter #(
    .PURE_ROTATION (1), .PARK_FIXED (1), .PARK_MASTER (3)
  ) i_pci_park_arbiter_pure (
    .clk (clk), .rst_n (rst_n), .req_n (req_n),
    .frame_n (frame_n), .irdy_n (irdy_n), .gnt_n (gnt_p_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // row: {req active[4:0], frame active, irdy active, fair grant[4:0], pure grant[4:0]}
  // all fields active-high here; the grant fields are the values seen before the row's inputs apply
  localparam logic [16:0] VEC [0:18] = '{
    17'b00000_0_0_00000_00000, // 0  reset exit, no grant yet
    17'b00100_0_0_00001_01000, // 1  parked: fair on 0, pure on 3
    17'b00100_0_0_00000_00000, // 2  gap
    17'b00100_1_0_00100_00100, // 3  master 2 owns, starts
    17'b00010_1_1_00100_00100, // 4  hidden: m1 asks while busy
    17'b00010_0_1_00000_00000, // 5  gap during last data phase
    17'b00010_0_0_00010_00010, // 6  m1 owns, waits for idle bus
    17'b00010_1_0_00010_00010, // 7  m1 starts
    17'b00000_0_0_00010_00010, // 8  no requests
    17'b00000_0_0_00010_00000, // 9  fair keeps m1, pure leaves
    17'b10001_0_0_00010_01000, // 10 pure parked on 3
    17'b10001_0_0_00000_00000, // 11 gap
    17'b10001_1_0_10000_10000, // 12 m4 owns, starts
    17'b10001_1_1_10000_10000, // 13 busy, others pending
    17'b10001_0_0_00000_00000, // 14 gap
    17'b10001_0_0_00001_10000, // 15 fair -> 0, pure -> 4
    17'b10001_1_0_00001_10000, // 16 start
    17'b10001_0_0_00001_10000, // 17 others pending
    17'b10001_0_0_00000_00000  // 18 gap
  };

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] r, input logic f, input logic i);
    req_n   = ~r;
    frame_n = ~f;
    irdy_n  = ~i;
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    drive(5'b00000, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R2 reset fair", gnt_f_n, 5'b11111);
    chk("R2 reset pure", gnt_p_n, 5'b11111);
    rst_n = 1'b1;

    // table walk: R3 gaps, R4/R5 parking, R6 hidden handover, R7 start, R9/R10 order
    for (int i = 0; i < 19; i++) begin
      chk($sformatf("R3/R4/R6/R7/R9 fair row %0d", i), ~gnt_f_n, VEC[i][9:5]);
      chk($sformatf("R3/R5/R6/R7/R10 pure row %0d", i), ~gnt_p_n, VEC[i][4:0]);
      chk($sformatf("R1 one grant row %0d", i),
          5'($countones(~gnt_f_n) <= 1 && $countones(~gnt_p_n) <= 1), 5'd1);
      drive(VEC[i][16:12], VEC[i][11], VEC[i][10]);
      @(negedge clk);
    end

    // R8: m4 holds an unused grant for 16 idle cycles while m1 waits
    for (int k = 0; k < 16; k++) begin
      chk($sformatf("R8 unused grant held k=%0d fair", k), ~gnt_f_n, 5'b10000);
      chk($sformatf("R8 unused grant held k=%0d pure", k), ~gnt_p_n, 5'b10000);
      drive(5'b10010, 1'b0, 1'b0);
      @(negedge clk);
    end
    chk("R8 grant withdrawn fair", ~gnt_f_n, 5'b00000);
    chk("R8 grant withdrawn pure", ~gnt_p_n, 5'b00000);
    @(negedge clk);
    chk("R8/R9 next master fair", ~gnt_f_n, 5'b00010);
    chk("R8/R10 next master pure", ~gnt_p_n, 5'b00010);

    // R2 mid-run reset, then parking restarts at master 0 (R5 fixed on 3)
    rst_n = 1'b0;
    drive(5'b00000, 1'b0, 1'b0);
    #1;
    chk("R2 async reset fair", gnt_f_n, 5'b11111);
    chk("R2 async reset pure", gnt_p_n, 5'b11111);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 park on master 0 after reset", ~gnt_f_n, 5'b00001);
    chk("R5 fixed park after reset", ~gnt_p_n, 5'b01000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule